// File: doc/BRIEF.md
# Colour Expansion Framebuffer Write Unit

This unit turns one byte written by the processor into up to eight pixel writes in a byte-addressed framebuffer. Each data bit selects a pixel. The most significant bit selects the pixel at the lowest address. A bit of one paints the foreground colour. A bit of zero paints the background colour in opaque mode. In transparent mode a zero bit leaves the pixel untouched. An 8-bit pixel mask can also block any pixel from being written.

Pixels are one byte wide or two bytes wide. In the two-byte depth, the low byte of each pixel comes from the low colour registers and the high byte comes from a separate pair of high colour registers.

The unit takes a job on a write strobe and captures every setting at that moment. It then steps through one byte slot per clock and drives a simple byte-write port. Skipped slots still take their clock cycle, so every written byte lands at the base offset plus its slot number. A busy flag covers the whole job, and a one-cycle done pulse marks its end.

Top module: `cexp_write_unit`

## Requirements
- R1: In the cycle after an accepted strobe, busy goes high. It stays high for exactly 8 cycles at one byte per pixel (`depth16`=0) or 16 cycles at two bytes per pixel (`depth16`=1). In the cycle after that, busy is low and done is high for exactly one cycle.
- R2: In busy cycle k (counting from 0), the port presents slot k at address offset+k. Pixel p = k at one byte per pixel, or p = k/2 with byte-in-pixel k mod 2 at two bytes per pixel. Pixel p uses data bit 7-p and mask bit 7-p.
- R3: When a pixel's mask bit is 1 and its data bit is 1, each of its byte slots writes the foreground colour, whatever the mode.
- R4: When a pixel's mask bit is 1 and its data bit is 0, each of its slots writes the background colour if `mode_opaque`=1, and is not written (mem_we=0) if `mode_opaque`=0.
- R5: When a pixel's mask bit is 0, none of its slots is written, whatever its data bit or the mode.
- R6: At two bytes per pixel, byte 0 of a pixel takes `fg_lo`/`bg_lo` and byte 1 takes `fg_hi`/`bg_hi`. At one byte per pixel only `fg_lo`/`bg_lo` are used.
- R7: A strobe that arrives while busy is high is ignored. The running job finishes unchanged and no further job starts.
- R8: Offset, data, mode, depth, mask and all four colours are captured when the strobe is accepted. Changes to these inputs during the job have no effect on it.
- R9: After reset, busy, done and mem_we are all 0.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Job request, accepted when busy is low |
| wr_offset | input | ADDR_W | Base byte address of the first pixel |
| wr_data | input | 8 | Pattern byte, one bit per pixel |
| mode_opaque | input | 1 | 1: zero bits paint the background; 0: zero bits are skipped |
| depth16 | input | 1 | 1: two bytes per pixel; 0: one byte per pixel |
| pix_mask | input | 8 | Per-pixel write enable, MSB for the first pixel |
| fg_lo | input | 8 | Foreground colour, low byte |
| bg_lo | input | 8 | Background colour, low byte |
| fg_hi | input | 8 | Foreground colour, high byte |
| bg_hi | input | 8 | Background colour, high byte |
| mem_we | output | 1 | Byte write enable |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse after the last slot |

## Verification
The inline assertions check the sequencing rules on every clock:
- done lasts exactly one cycle and follows the fall of busy.
- The address climbs by one between consecutive busy cycles.
- The captured base address holds through the job while busy stays high.
- No write happens outside busy.
- In transparent mode, every write carries a foreground byte.

The bench scenarios must show the rest:
- the colour selection for each combination of data bit, mask bit, mode and depth;
- MSB-first ordering;
- address wrap;
- that strobes and input changes during a job leave the job untouched.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

    localparam int PIX_PER_JOB = 8;
    localparam int SLOT_W      = $clog2(2 * PIX_PER_JOB);
    localparam int PIX_W       = $clog2(PIX_PER_JOB);

    typedef struct packed {
        logic [7:0] pattern;
        logic [7:0] mask;
        logic       opaque;
        logic       wide;
        logic [7:0] fg_lo;
        logic [7:0] bg_lo;
        logic [7:0] fg_hi;
        logic [7:0] bg_hi;
    } job_t;

    function automatic logic [SLOT_W-1:0] last_slot(input logic wide);
        return wide ? SLOT_W'(2 * PIX_PER_JOB - 1) : SLOT_W'(PIX_PER_JOB - 1);
    endfunction

    function automatic logic [7:0] pick_colour(input job_t j, input logic fg, input logic hi);
        logic [7:0] c;
        if (fg) c = hi ? j.fg_hi : j.fg_lo;
        else    c = hi ? j.bg_hi : j.bg_lo;
        return c;
    endfunction

endpackage

// File: rtl/cexp_seq.sv
module cexp_seq
    import cexp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wide_in,
    input  logic [ADDR_W-1:0] base_in,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] addr
);

    logic              wide_q;
    logic [ADDR_W-1:0] base_q;
    logic              at_end;

    assign accept = req && !busy;
    assign at_end = (slot == last_slot(wide_q));
    assign addr   = base_q + ADDR_W'(slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            slot   <= '0;
            wide_q <= 1'b0;
            base_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (req) begin
                    busy   <= 1'b1;
                    slot   <= '0;
                    wide_q <= wide_in;
                    base_q <= base_in;
                end
            end else begin
                slot <= slot + 1'b1;
                if (at_end) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (addr == $past(addr) + 1'b1));
    assert_job_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !at_end) |=> (busy && $stable(base_q)));

endmodule

// File: rtl/cexp_slot_gen.sv
module cexp_slot_gen
    import cexp_pkg::*;
(
    input  job_t              job,
    input  logic [SLOT_W-1:0] slot,
    output logic              slot_we,
    output logic              slot_hi,
    output logic [7:0]        slot_data
);

    logic [PIX_W-1:0] pix;
    logic [PIX_W-1:0] bitpos;
    logic             dbit;
    logic             mbit;

    always_comb begin
        pix       = job.wide ? slot[SLOT_W-1:1] : slot[PIX_W-1:0];
        bitpos    = PIX_W'(PIX_PER_JOB - 1) - pix;
        dbit      = job.pattern[bitpos];
        mbit      = job.mask[bitpos];
        slot_hi   = job.wide & slot[0];
        slot_we   = mbit & (dbit | job.opaque);
        slot_data = pick_colour(job, dbit, slot_hi);
    end

endmodule

// File: rtl/cexp_write_unit.sv
module cexp_write_unit
    import cexp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_offset,
    input  logic [7:0]        wr_data,
    input  logic              mode_opaque,
    input  logic              depth16,
    input  logic [7:0]        pix_mask,
    input  logic [7:0]        fg_lo,
    input  logic [7:0]        bg_lo,
    input  logic [7:0]        fg_hi,
    input  logic [7:0]        bg_hi,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done
);

    job_t              job_q;
    logic              accept;
    logic [SLOT_W-1:0] slot;
    logic              slot_we;
    logic              slot_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q <= '0;
        end else if (accept) begin
            job_q <= '{pattern: wr_data, mask: pix_mask, opaque: mode_opaque,
                       wide: depth16, fg_lo: fg_lo, bg_lo: bg_lo,
                       fg_hi: fg_hi, bg_hi: bg_hi};
        end
    end

    cexp_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (wr_stb),
        .wide_in (depth16),
        .base_in (wr_offset),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .slot    (slot),
        .addr    (mem_addr)
    );

    cexp_slot_gen u_gen (
        .job       (job_q),
        .slot      (slot),
        .slot_we   (slot_we),
        .slot_hi   (slot_hi),
        .slot_data (mem_wdata)
    );

    assign mem_we = busy & slot_we;

    assert_we_in_job_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);
    assert_transparent_fg_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !job_q.opaque) |->
            (mem_wdata == (slot_hi ? job_q.fg_hi : job_q.fg_lo)));
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_we));

endmodule

// File: tb/cexp_write_unit_test.sv
module cexp_write_unit_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_offset = '0;
    logic [7:0]    wr_data = '0;
    logic          mode_opaque = 1'b0;
    logic          depth16 = 1'b0;
    logic [7:0]    pix_mask = '0;
    logic [7:0]    fg_lo = '0, bg_lo = '0, fg_hi = '0, bg_hi = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy, done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cexp_write_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_offset(wr_offset),
        .wr_data(wr_data), .mode_opaque(mode_opaque), .depth16(depth16),
        .pix_mask(pix_mask), .fg_lo(fg_lo), .bg_lo(bg_lo), .fg_hi(fg_hi),
        .bg_hi(bg_hi), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected behaviour of slot k, taken from the requirements
    function automatic bit exp_we(int k, bit wide, bit opq, logic [7:0] d, logic [7:0] m);
        int p = wide ? k / 2 : k;
        return m[7-p] && (d[7-p] || opq);
    endfunction

    function automatic logic [7:0] exp_byte(int k, bit wide, logic [7:0] d,
                                            logic [7:0] f0, logic [7:0] b0,
                                            logic [7:0] f1, logic [7:0] b1);
        int p = wide ? k / 2 : k;
        bit hi = wide && (k % 2 == 1);
        if (d[7-p]) return hi ? f1 : f0;
        return hi ? b1 : b0;
    endfunction

    // Runs one job; optional strobe during the job (R7) and input scrambling (R8)
    task automatic run_job(input logic [AW-1:0] off, input logic [7:0] d,
                           input bit opq, input bit wide, input logic [7:0] m,
                           input logic [7:0] f0, input logic [7:0] b0,
                           input logic [7:0] f1, input logic [7:0] b1,
                           input bit poke, input bit scramble);
        int n = wide ? 16 : 8;
        @(negedge clk);
        wr_offset = off; wr_data = d; mode_opaque = opq; depth16 = wide;
        pix_mask = m; fg_lo = f0; bg_lo = b0; fg_hi = f1; bg_hi = b1;
        wr_stb = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_stb = 1'b0;
            if (scramble) begin
                wr_offset = AW'($urandom); wr_data = 8'($urandom);
                mode_opaque = ~opq; depth16 = ~wide; pix_mask = 8'($urandom);
                fg_lo = 8'($urandom); bg_lo = 8'($urandom);
                fg_hi = 8'($urandom); bg_hi = 8'($urandom);
            end
            chk(busy === 1'b1, "R1 busy", int'(busy), 1);
            chk(mem_addr === AW'(off + AW'(k)), "R2/R10 addr", int'(mem_addr), int'(AW'(off + AW'(k))));
            if (exp_we(k, wide, opq, d, m)) begin
                chk(mem_we === 1'b1, "R3/R4 write", int'(mem_we), 1);
                chk(mem_wdata === exp_byte(k, wide, d, f0, b0, f1, b1),
                    "R3/R4/R6 data", int'(mem_wdata), int'(exp_byte(k, wide, d, f0, b0, f1, b1)));
            end else begin
                chk(mem_we === 1'b0, "R4/R5 skip", int'(mem_we), 0);
            end
            if (poke && k < n - 2) wr_stb = 1'b1;
        end
        @(negedge clk);
        wr_stb = 1'b0;
        chk(busy === 1'b0, "R1/R7 busy low", int'(busy), 0);
        chk(done === 1'b1, "R1 done", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R1 done pulse", int'(done), 0);
        chk(busy === 1'b0, "R7 no new job", int'(busy), 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9 busy", int'(busy), 0);
        chk(done === 1'b0, "R9 done", int'(done), 0);
        chk(mem_we === 1'b0, "R9 we", int'(mem_we), 0);
        rst = 1'b0;
        // directed corners
        run_job(16'h0100, 8'hA5, 1'b0, 1'b0, 8'hFF, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0); // R4 transparent
        run_job(16'h0200, 8'hA5, 1'b1, 1'b0, 8'hFF, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0); // R4 opaque
        run_job(16'h0300, 8'hFF, 1'b1, 1'b1, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0); // R5 all masked
        run_job(16'h0400, 8'h3C, 1'b1, 1'b1, 8'hF0, 8'h5A, 8'hC3, 8'h96, 8'h69, 0, 0); // R6 wide
        run_job(16'h0500, 8'h80, 1'b0, 1'b0, 8'h80, 8'hEE, 8'h00, 8'h00, 8'h00, 0, 0); // R2 MSB first
        run_job(16'hFFFA, 8'hFF, 1'b1, 1'b1, 8'hFF, 8'h01, 8'h02, 8'h03, 8'h04, 0, 0); // R10 wrap
        run_job(16'h0600, 8'hC3, 1'b1, 1'b0, 8'hBD, 8'h71, 8'h72, 8'h73, 8'h74, 1, 0); // R7
        run_job(16'h0700, 8'h96, 1'b0, 1'b1, 8'hE7, 8'h81, 8'h82, 8'h83, 8'h84, 0, 1); // R8
        // constrained random
        for (int i = 0; i < 60; i++) begin
            run_job(AW'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                    8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                    8'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule